// File: doc/BRIEF.md
# Bus-Cycle Access Trigger Comparator

This block watches the program counter of retired instructions and every operand bus cycle, and raises a one-cycle trigger when a programmed condition is met. It holds three comparators: one for the program counter, one for the operand address, and one for the operand data value. The address comparator works either on a single address or on an inclusive from–to window. The data comparator first moves the active byte lanes of the bus word down to the least significant end, using the two low address bits and the access size, and then compares the result under a bit mask. A filter on the access direction can limit both the address and the data comparators to reads, to writes, or let them accept either.

A mode field selects how the three results combine. The combinational modes fire in the same cycle as their inputs. The sequential modes need two steps: a first-level match arms the block, and a later second-level match fires it. The registers are loaded through a plain indexed write port. Any write to these registers disarms a pending sequence.

Top module: `trigcmp_top`

## Requirements
- R1: After reset, `trig` is low, the block is disarmed, and every register holds zero. Mode 0 is "off", so no input pattern raises `trig` until software writes a mode.
- R2: When `cfg_we` is high, `cfg_wdata` is written to the register selected by `cfg_idx`. Index 0 is control: bits [3:0] hold the mode, bits [5:4] hold the direction filter, and bit 8 enables range matching. Index 1 is the PC target. Index 2 is the address low bound, or the equal value. Index 3 is the address high bound. Index 4 is the data value. Index 5 is the data mask, where a 1 means the bit is compared. Indexes 6 and 7 are ignored.
- R3: `trig` is a registered output. It is high for exactly the one cycle after each cycle whose inputs satisfy the mode, and low in every other cycle.
- R4: A PC match needs `pc_valid` high and `pc` equal to the PC target. Mode 2 (PC) fires on that match alone.
- R5: An address match needs an accepted bus cycle. With range matching disabled, `bus_addr` must equal the low bound. With range matching enabled, the low bound ≤ `bus_addr` ≤ the high bound, with both ends inclusive. Mode 3 fires on an address match.
- R6: The direction filter decides which bus cycles are accepted. A filter of 1 accepts only reads (`bus_write`=0). A filter of 2 accepts only writes. A filter of 0 or 3 accepts either. Both the address and the data comparators apply the filter.
- R7: For byte accesses (`bus_size`=0), address bits [1:0] = 0, 1, 2 and 3 select data bits 31:24, 23:16, 15:8 and 7:0 of `bus_data`, and these are compared with bits 7:0 of the data value.
- R8: For word accesses (`bus_size`=1), bits 31:16 are used when address bit 1 is 0, and bits 15:0 when it is 1. These are compared with bits 15:0 of the value. Longword accesses (`bus_size` 2 or 3) compare all 32 bits. In every size, only the bits set in the mask take part. Mode 4 fires on a data match.
- R9: The combined modes are evaluated within one cycle. Mode 1 fires on any cycle with `pc_valid` or `bus_valid` high. Mode 5 needs the address and the data to match in the same bus cycle. Mode 6 fires on PC or address. Mode 7 fires on PC, or on address and data matching together.
- R10: The sequential modes are: 8 PC then address, 9 PC then data, 10 PC then (address and data), 11 address then PC, 12 data then PC, 13 (address and data) then PC. A first-level match arms the block. A second-level match in a later cycle fires it and disarms it. A second-level match in the same cycle as the arming match does not fire.
- R11: Any register write disarms the block at the next edge. A sequence that was already armed then needs a fresh first-level match.
- R12: Modes 0, 14 and 15 never raise `trig`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_idx | input | 3 | Register index |
| cfg_wdata | input | 32 | Register write data |
| pc_valid | input | 1 | An instruction address is presented |
| pc | input | ADDR_W | Executed instruction address |
| bus_valid | input | 1 | An operand bus cycle is presented |
| bus_addr | input | ADDR_W | Operand address |
| bus_size | input | 2 | 0 byte, 1 word, 2/3 longword |
| bus_write | input | 1 | 1 write, 0 read |
| bus_data | input | 32 | Operand data as seen on the 32-bit bus |
| trig | output | 1 | One-cycle trigger pulse |

## Verification
The bench builds the block with its default `ADDR_W` of 32. This lets one address window run up to 0xFFFF_FFFF, so the inclusive upper bound is checked at the very top of the space, where an off-by-one or a wrapping compare would show. Full 32-bit data words make every byte lane and both word halves reachable. Masked compares then show that unmasked bits really are ignored. Each sequential mode is driven through arm, fire and disarm, and also through a same-cycle first-and-second match and a reprogramming write between the two levels.

// File: rtl/trigcmp_pkg.sv
`timescale 1ns/1ps
package trigcmp_pkg;

  localparam int DATA_W = 32;

  localparam logic [3:0] M_OFF        = 4'd0;
  localparam logic [3:0] M_ANY        = 4'd1;
  localparam logic [3:0] M_PC         = 4'd2;
  localparam logic [3:0] M_ADDR       = 4'd3;
  localparam logic [3:0] M_DATA       = 4'd4;
  localparam logic [3:0] M_AD         = 4'd5;
  localparam logic [3:0] M_PC_OR_A    = 4'd6;
  localparam logic [3:0] M_PC_OR_AD   = 4'd7;
  localparam logic [3:0] M_PC_THEN_A  = 4'd8;
  localparam logic [3:0] M_PC_THEN_D  = 4'd9;
  localparam logic [3:0] M_PC_THEN_AD = 4'd10;
  localparam logic [3:0] M_A_THEN_PC  = 4'd11;
  localparam logic [3:0] M_D_THEN_PC  = 4'd12;
  localparam logic [3:0] M_AD_THEN_PC = 4'd13;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_WORD = 2'd1;

  localparam logic [2:0] IDX_CTRL  = 3'd0;
  localparam logic [2:0] IDX_PC    = 3'd1;
  localparam logic [2:0] IDX_ALO   = 3'd2;
  localparam logic [2:0] IDX_AHI   = 3'd3;
  localparam logic [2:0] IDX_DVAL  = 3'd4;
  localparam logic [2:0] IDX_DMASK = 3'd5;

  // True for the two-level modes.
  function automatic logic is_seq(input logic [3:0] m);
    return (m >= M_PC_THEN_A) && (m <= M_AD_THEN_PC);
  endfunction

  // Moves the active byte lanes of a bus word down to bit 0.
  function automatic logic [DATA_W-1:0] lane_pick(input logic [DATA_W-1:0] d,
                                                  input logic [1:0] a,
                                                  input logic [1:0] sz);
    logic [4:0] sh;
    if (sz == SZ_BYTE)      sh = {(2'd3 - a), 3'b000};
    else if (sz == SZ_WORD) sh = a[1] ? 5'd0 : 5'd16;
    else                    sh = 5'd0;
    return d >> sh;
  endfunction

  // The bits that are significant for a given access size.
  function automatic logic [DATA_W-1:0] size_bits(input logic [1:0] sz);
    if (sz == SZ_BYTE)      return 32'h0000_00FF;
    else if (sz == SZ_WORD) return 32'h0000_FFFF;
    else                    return 32'hFFFF_FFFF;
  endfunction

  // Direction filter: 1 reads only, 2 writes only, otherwise either.
  function automatic logic dir_ok(input logic [1:0] filt, input logic wr);
    if (filt == 2'd1)      return !wr;
    else if (filt == 2'd2) return wr;
    else                   return 1'b1;
  endfunction

endpackage

// File: rtl/trigcmp_pc_cmp.sv
`timescale 1ns/1ps
module trigcmp_pc_cmp #(
  parameter int ADDR_W = 32
) (
  input  logic              pc_valid,
  input  logic [ADDR_W-1:0] pc,
  input  logic [ADDR_W-1:0] target,
  output logic              hit
);
  assign hit = pc_valid && (pc == target);
endmodule

// File: rtl/trigcmp_addr_cmp.sv
`timescale 1ns/1ps
module trigcmp_addr_cmp #(
  parameter int ADDR_W = 32
) (
  input  logic              cyc_ok,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] lo,
  input  logic [ADDR_W-1:0] hi,
  input  logic              range_en,
  output logic              hit
);
  logic in_win;
  logic eq;
  assign eq     = (addr == lo);
  assign in_win = (addr >= lo) && (addr <= hi);
  assign hit    = cyc_ok && (range_en ? in_win : eq);
endmodule

// File: rtl/trigcmp_data_cmp.sv
`timescale 1ns/1ps
module trigcmp_data_cmp
  import trigcmp_pkg::*;
(
  input  logic              cyc_ok,
  input  logic [1:0]        addr_lo,
  input  logic [1:0]        size,
  input  logic [DATA_W-1:0] data,
  input  logic [DATA_W-1:0] value,
  input  logic [DATA_W-1:0] mask,
  output logic              hit
);
  logic [DATA_W-1:0] aligned;
  logic [DATA_W-1:0] care;
  assign aligned = lane_pick(data, addr_lo, size);
  assign care    = mask & size_bits(size);
  assign hit     = cyc_ok && (((aligned ^ value) & care) == '0);
endmodule

// File: rtl/trigcmp_seq.sv
`timescale 1ns/1ps
module trigcmp_seq
  import trigcmp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       disarm,
  input  logic [3:0] mode,
  input  logic       any_evt,
  input  logic       pc_hit,
  input  logic       addr_hit,
  input  logic       data_hit,
  output logic       fire,
  output logic       armed
);
  logic ad_hit;
  logic comb_fire;
  logic first_lvl;
  logic second_lvl;
  logic seq_mode;

  assign ad_hit   = addr_hit && data_hit;
  assign seq_mode = is_seq(mode);

  always_comb begin
    comb_fire  = 1'b0;
    first_lvl  = 1'b0;
    second_lvl = 1'b0;
    case (mode)
      M_ANY:        comb_fire = any_evt;
      M_PC:         comb_fire = pc_hit;
      M_ADDR:       comb_fire = addr_hit;
      M_DATA:       comb_fire = data_hit;
      M_AD:         comb_fire = ad_hit;
      M_PC_OR_A:    comb_fire = pc_hit || addr_hit;
      M_PC_OR_AD:   comb_fire = pc_hit || ad_hit;
      M_PC_THEN_A:  begin first_lvl = pc_hit;   second_lvl = addr_hit; end
      M_PC_THEN_D:  begin first_lvl = pc_hit;   second_lvl = data_hit; end
      M_PC_THEN_AD: begin first_lvl = pc_hit;   second_lvl = ad_hit;   end
      M_A_THEN_PC:  begin first_lvl = addr_hit; second_lvl = pc_hit;   end
      M_D_THEN_PC:  begin first_lvl = data_hit; second_lvl = pc_hit;   end
      M_AD_THEN_PC: begin first_lvl = ad_hit;   second_lvl = pc_hit;   end
      default:      comb_fire = 1'b0;
    endcase
  end

  assign fire = seq_mode ? (armed && second_lvl) : comb_fire;

  always_ff @(posedge clk) begin
    if (!rst_n)                  armed <= 1'b0;
    else if (disarm || !seq_mode) armed <= 1'b0;
    else if (fire)               armed <= 1'b0;
    else if (first_lvl)          armed <= 1'b1;
  end
endmodule

// File: rtl/trigcmp_top.sv
`timescale 1ns/1ps
module trigcmp_top
  import trigcmp_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_idx,
  input  logic [31:0]       cfg_wdata,
  input  logic              pc_valid,
  input  logic [ADDR_W-1:0] pc,
  input  logic              bus_valid,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic              bus_write,
  input  logic [31:0]       bus_data,
  output logic              trig
);
  logic [3:0]        mode_q;
  logic [1:0]        filt_q;
  logic              range_q;
  logic [ADDR_W-1:0] pc_tgt_q;
  logic [ADDR_W-1:0] alo_q;
  logic [ADDR_W-1:0] ahi_q;
  logic [DATA_W-1:0] dval_q;
  logic [DATA_W-1:0] dmask_q;

  logic bus_ok;
  logic pc_hit;
  logic addr_hit;
  logic data_hit;
  logic fire;
  logic armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= M_OFF;
      filt_q   <= '0;
      range_q  <= 1'b0;
      pc_tgt_q <= '0;
      alo_q    <= '0;
      ahi_q    <= '0;
      dval_q   <= '0;
      dmask_q  <= '0;
    end else if (cfg_we) begin
      case (cfg_idx)
        IDX_CTRL: begin
          mode_q  <= cfg_wdata[3:0];
          filt_q  <= cfg_wdata[5:4];
          range_q <= cfg_wdata[8];
        end
        IDX_PC:    pc_tgt_q <= cfg_wdata[ADDR_W-1:0];
        IDX_ALO:   alo_q    <= cfg_wdata[ADDR_W-1:0];
        IDX_AHI:   ahi_q    <= cfg_wdata[ADDR_W-1:0];
        IDX_DVAL:  dval_q   <= cfg_wdata;
        IDX_DMASK: dmask_q  <= cfg_wdata;
        default: ;
      endcase
    end
  end

  assign bus_ok = bus_valid && dir_ok(filt_q, bus_write);

  trigcmp_pc_cmp #(.ADDR_W(ADDR_W)) u_pc (
    .pc_valid(pc_valid), .pc(pc), .target(pc_tgt_q), .hit(pc_hit)
  );

  trigcmp_addr_cmp #(.ADDR_W(ADDR_W)) u_addr (
    .cyc_ok(bus_ok), .addr(bus_addr), .lo(alo_q), .hi(ahi_q),
    .range_en(range_q), .hit(addr_hit)
  );

  trigcmp_data_cmp u_data (
    .cyc_ok(bus_ok), .addr_lo(bus_addr[1:0]), .size(bus_size),
    .data(bus_data), .value(dval_q), .mask(dmask_q), .hit(data_hit)
  );

  trigcmp_seq u_seq (
    .clk(clk), .rst_n(rst_n), .disarm(cfg_we), .mode(mode_q),
    .any_evt(pc_valid || bus_valid), .pc_hit(pc_hit),
    .addr_hit(addr_hit), .data_hit(data_hit), .fire(fire), .armed(armed)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) trig <= 1'b0;
    else        trig <= fire;
  end
endmodule

// File: rtl/trigcmp_chk.sv
`timescale 1ns/1ps
module trigcmp_chk
  import trigcmp_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_we,
  input logic [3:0] mode,
  input logic       armed,
  input logic       pc_hit,
  input logic       pc_valid,
  input logic       bus_valid,
  input logic       trig
);
  assert_trig_has_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> $past(pc_valid || bus_valid));

  assert_pc_fires_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_PC && pc_hit) |=> trig);

  assert_comb_never_armed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !is_seq(mode) |=> !armed);

  assert_seq_needs_arm_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (is_seq(mode) && !armed) |=> !trig);

  assert_write_disarms_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> !armed);

  assert_off_silent_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_OFF || mode > M_AD_THEN_PC) |=> !trig);
endmodule

bind trigcmp_top trigcmp_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .mode(mode_q), .armed(armed),
  .pc_hit(pc_hit), .pc_valid(pc_valid), .bus_valid(bus_valid), .trig(trig)
);

// File: tb/trigcmp_top_test.sv
`timescale 1ns/1ps
module trigcmp_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic [31:0] cfg_wdata = '0;
  logic        pc_valid = 1'b0;
  logic [31:0] pc = '0;
  logic        bus_valid = 1'b0;
  logic [31:0] bus_addr = '0;
  logic [1:0]  bus_size = '0;
  logic        bus_write = 1'b0;
  logic [31:0] bus_data = '0;
  logic        trig;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  logic  exp_q[$];
  string tag_q[$];

  // Model state.
  logic [3:0]  m_mode = 0;
  logic [1:0]  m_filt = 0;
  logic        m_rng = 0;
  logic [31:0] m_pc = 0, m_lo = 0, m_hi = 0, m_val = 0, m_msk = 0;
  logic        m_arm = 0;

  always #10 clk = ~clk;

  trigcmp_top uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .pc_valid(pc_valid), .pc(pc),
    .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_size(bus_size),
    .bus_write(bus_write), .bus_data(bus_data), .trig(trig)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: trig=%0b expected %0b", tag, act, exp);
    end
  endtask

  // Model of one cycle; returns whether the trigger is due.
  function automatic logic model_cycle(input logic we);
    logic acc, ph, ah, dh, adh, f1, f2, seq, fire;
    logic [31:0] sel, cmpmask;
    acc = bus_valid && ((m_filt == 2'd1) ? !bus_write :
                        (m_filt == 2'd2) ? bus_write : 1'b1);
    ph  = pc_valid && (pc == m_pc);
    ah  = acc && (m_rng ? (bus_addr >= m_lo && bus_addr <= m_hi) : bus_addr == m_lo);
    case (bus_size)
      2'd0: begin
        cmpmask = 32'hFF;
        case (bus_addr[1:0])
          2'd0: sel = {24'd0, bus_data[31:24]};
          2'd1: sel = {24'd0, bus_data[23:16]};
          2'd2: sel = {24'd0, bus_data[15:8]};
          default: sel = {24'd0, bus_data[7:0]};
        endcase
      end
      2'd1: begin
        cmpmask = 32'hFFFF;
        sel = bus_addr[1] ? {16'd0, bus_data[15:0]} : {16'd0, bus_data[31:16]};
      end
      default: begin cmpmask = '1; sel = bus_data; end
    endcase
    dh  = acc && ((sel & m_msk & cmpmask) == (m_val & m_msk & cmpmask));
    adh = ah && dh;
    seq = 1'b1; f1 = 0; f2 = 0; fire = 0;
    case (m_mode)
      4'd8:  begin f1 = ph;  f2 = ah;  end
      4'd9:  begin f1 = ph;  f2 = dh;  end
      4'd10: begin f1 = ph;  f2 = adh; end
      4'd11: begin f1 = ah;  f2 = ph;  end
      4'd12: begin f1 = dh;  f2 = ph;  end
      4'd13: begin f1 = adh; f2 = ph;  end
      default: seq = 1'b0;
    endcase
    if (seq) fire = m_arm && f2;
    else case (m_mode)
      4'd1: fire = pc_valid || bus_valid;
      4'd2: fire = ph;
      4'd3: fire = ah;
      4'd4: fire = dh;
      4'd5: fire = adh;
      4'd6: fire = ph || ah;
      4'd7: fire = ph || adh;
      default: fire = 1'b0;
    endcase
    if (we || !seq || fire) m_arm = 1'b0;
    else if (f1)           m_arm = 1'b1;
    return fire;
  endfunction

  task automatic push(input string tag);
    exp_q.push_back(model_cycle(cfg_we));
    tag_q.push_back(tag);
  endtask

  task automatic idle_inputs();
    cfg_we = 0; pc_valid = 0; bus_valid = 0;
  endtask

  task automatic wr(input logic [2:0] idx, input logic [31:0] v, input string tag);
    @(negedge clk);
    idle_inputs();
    cfg_we = 1; cfg_idx = idx; cfg_wdata = v;
    push(tag);
    case (idx)
      3'd0: begin m_mode = v[3:0]; m_filt = v[5:4]; m_rng = v[8]; end
      3'd1: m_pc = v;
      3'd2: m_lo = v;
      3'd3: m_hi = v;
      3'd4: m_val = v;
      3'd5: m_msk = v;
      default: ;
    endcase
  endtask

  task automatic cyc(input logic pv, input logic [31:0] p,
                     input logic bv, input logic [31:0] a, input logic [1:0] sz,
                     input logic w, input logic [31:0] d, input string tag);
    @(negedge clk);
    idle_inputs();
    pc_valid = pv; pc = p; bus_valid = bv; bus_addr = a;
    bus_size = sz; bus_write = w; bus_data = d;
    push(tag);
  endtask

  task automatic idle(input string tag);
    cyc(0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  // Monitor: compares each result one edge after it was driven.
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (exp_q.size() > 0) check(tag_q.pop_front(), trig, exp_q.pop_front());
    end
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 trig low in reset", trig, 1'b0);
    pc_valid = 1; bus_valid = 1;
    @(negedge clk);
    check("R1 reset ignores inputs", trig, 1'b0);
    idle_inputs();
    rst_n = 1;
    cyc(1, 0, 1, 0, 2, 1, 0, "R1 mode off after reset");
    idle("R1 idle");

    // PC mode and pulse shape
    wr(3'd1, 32'h1000, "R2 write pc");
    wr(3'd0, 32'h2, "R2 write ctrl pc");
    cyc(1, 32'h1000, 0, 0, 0, 0, 0, "R4 pc hit");
    cyc(1, 32'h1004, 0, 0, 0, 0, 0, "R4 pc miss");
    cyc(0, 32'h1000, 0, 0, 0, 0, 0, "R4 pc not valid");
    cyc(1, 32'h1000, 0, 0, 0, 0, 0, "R3 back to back 1");
    cyc(1, 32'h1000, 0, 0, 0, 0, 0, "R3 back to back 2");
    idle("R3 pulse ends");
    wr(3'd6, 32'h0, "R2 index 6 ignored");
    cyc(1, 32'h1000, 0, 0, 0, 0, 0, "R2 pc kept after ignored write");

    // Address equal and range
    wr(3'd2, 32'h2000, "R5 lo");
    wr(3'd0, 32'h3, "R5 addr equal mode");
    cyc(0, 0, 1, 32'h2000, 2, 0, 0, "R5 equal hit");
    cyc(0, 0, 1, 32'h2004, 2, 0, 0, "R5 equal miss");
    wr(3'd3, 32'h20FF, "R5 hi");
    wr(3'd0, 32'h103, "R5 range mode");
    cyc(0, 0, 1, 32'h1FFF, 2, 0, 0, "R5 below range");
    cyc(0, 0, 1, 32'h2000, 2, 0, 0, "R5 low edge");
    cyc(0, 0, 1, 32'h20FF, 2, 0, 0, "R5 high edge");
    cyc(0, 0, 1, 32'h2100, 2, 0, 0, "R5 above range");
    wr(3'd2, 32'hFFFF_FF00, "R5 top lo");
    wr(3'd3, 32'hFFFF_FFFF, "R5 top hi");
    cyc(0, 0, 1, 32'hFFFF_FFFF, 2, 0, 0, "R5 top of space");
    cyc(0, 0, 1, 32'h0, 2, 0, 0, "R5 no wrap");

    // Direction filter
    wr(3'd0, 32'h123, "R6 writes only");
    cyc(0, 0, 1, 32'hFFFF_FF10, 2, 1, 0, "R6 write accepted");
    cyc(0, 0, 1, 32'hFFFF_FF10, 2, 0, 0, "R6 read rejected");
    wr(3'd0, 32'h113, "R6 reads only");
    cyc(0, 0, 1, 32'hFFFF_FF10, 2, 0, 0, "R6 read accepted");
    cyc(0, 0, 1, 32'hFFFF_FF10, 2, 1, 0, "R6 write rejected");

    // Byte lanes
    wr(3'd4, 32'hAB, "R7 value");
    wr(3'd5, 32'hFF, "R7 mask");
    wr(3'd0, 32'h4, "R7 data mode");
    cyc(0, 0, 1, 32'h40, 0, 0, 32'hAB00_0000, "R7 lane 0");
    cyc(0, 0, 1, 32'h41, 0, 0, 32'h00AB_0000, "R7 lane 1");
    cyc(0, 0, 1, 32'h42, 0, 0, 32'h0000_AB00, "R7 lane 2");
    cyc(0, 0, 1, 32'h43, 0, 0, 32'h0000_00AB, "R7 lane 3");
    cyc(0, 0, 1, 32'h40, 0, 0, 32'h0000_00AB, "R7 wrong lane");

    // Word, longword, mask
    wr(3'd4, 32'h1234, "R8 value");
    wr(3'd5, 32'hFFFF, "R8 mask");
    cyc(0, 0, 1, 32'h40, 1, 0, 32'h1234_0000, "R8 upper half");
    cyc(0, 0, 1, 32'h42, 1, 0, 32'h0000_1234, "R8 lower half");
    cyc(0, 0, 1, 32'h42, 1, 0, 32'h1234_0000, "R8 wrong half");
    wr(3'd4, 32'hDEAD_BEEF, "R8 long value");
    wr(3'd5, 32'hFFFF_0000, "R8 long mask");
    cyc(0, 0, 1, 32'h40, 2, 0, 32'hDEAD_0000, "R8 masked bits ignored");
    cyc(0, 0, 1, 32'h40, 2, 0, 32'hDEAC_BEEF, "R8 compared bit differs");

    // Combined modes
    wr(3'd2, 32'h3000, "R9 lo");
    wr(3'd0, 32'h5, "R9 addr and data");
    cyc(0, 0, 1, 32'h3000, 2, 0, 32'h1111_0000, "R9 addr only");
    cyc(0, 0, 1, 32'h3004, 2, 0, 32'hDEAD_0000, "R9 data only");
    cyc(0, 0, 1, 32'h3000, 2, 0, 32'hDEAD_0000, "R9 both");
    wr(3'd0, 32'h6, "R9 pc or addr");
    cyc(1, 32'h1000, 0, 0, 0, 0, 0, "R9 pc side");
    cyc(0, 0, 1, 32'h3000, 2, 0, 0, "R9 addr side");
    wr(3'd0, 32'h7, "R9 pc or addr-data");
    cyc(0, 0, 1, 32'h3000, 2, 0, 0, "R9 addr without data");
    cyc(0, 0, 1, 32'h3000, 2, 0, 32'hDEAD_0000, "R9 addr with data");
    wr(3'd0, 32'h1, "R9 anything");
    idle("R9 anything idle");
    cyc(0, 0, 1, 32'h9999, 0, 1, 0, "R9 anything bus");

    // Sequential modes
    wr(3'd0, 32'h8, "R10 pc then addr");
    cyc(0, 0, 1, 32'h3000, 2, 0, 0, "R10 second before first");
    cyc(1, 32'h1000, 1, 32'h3000, 2, 0, 0, "R10 same cycle no fire");
    idle("R10 armed idle");
    cyc(0, 0, 1, 32'h3000, 2, 0, 0, "R10 fire later");
    cyc(0, 0, 1, 32'h3000, 2, 0, 0, "R10 disarmed after fire");
    wr(3'd0, 32'hB, "R10 addr then pc");
    cyc(0, 0, 1, 32'h3000, 2, 0, 0, "R10 arm by addr");
    cyc(1, 32'h1000, 0, 0, 0, 0, 0, "R10 fire by pc");
    wr(3'd0, 32'hC, "R10 data then pc");
    cyc(0, 0, 1, 32'h50, 2, 0, 32'hDEAD_1111, "R10 arm by data");
    cyc(1, 32'h1000, 0, 0, 0, 0, 0, "R10 fire after data");
    wr(3'd0, 32'hA, "R10 pc then addr-data");
    cyc(1, 32'h1000, 0, 0, 0, 0, 0, "R10 arm pc");
    cyc(0, 0, 1, 32'h3000, 2, 0, 0, "R10 addr alone no fire");
    cyc(0, 0, 1, 32'h3000, 2, 0, 32'hDEAD_0000, "R10 addr-data fires");
    wr(3'd0, 32'hD, "R10 addr-data then pc");
    cyc(0, 0, 1, 32'h3000, 2, 0, 32'hDEAD_0000, "R10 arm ad");
    cyc(1, 32'h1000, 0, 0, 0, 0, 0, "R10 fire ad then pc");
    wr(3'd0, 32'h9, "R10 pc then data");
    cyc(1, 32'h1000, 0, 0, 0, 0, 0, "R10 arm pc d");
    cyc(0, 0, 1, 32'h70, 2, 0, 32'hDEAD_2222, "R10 data fires");

    // Reprogramming disarms
    wr(3'd0, 32'h8, "R11 pc then addr");
    cyc(1, 32'h1000, 0, 0, 0, 0, 0, "R11 arm");
    wr(3'd1, 32'h1000, "R11 rewrite same pc");
    cyc(0, 0, 1, 32'h3000, 2, 0, 0, "R11 no fire after write");

    // Disabled modes
    wr(3'd0, 32'hE, "R12 mode 14");
    cyc(1, 32'h1000, 1, 32'h3000, 2, 0, 32'hDEAD_0000, "R12 mode 14 silent");
    wr(3'd0, 32'hF, "R12 mode 15");
    cyc(1, 32'h1000, 1, 32'h3000, 2, 0, 32'hDEAD_0000, "R12 mode 15 silent");
    wr(3'd0, 32'h0, "R12 mode 0");
    cyc(1, 32'h1000, 1, 32'h3000, 2, 0, 32'hDEAD_0000, "R12 mode 0 silent");
    idle("end");
    repeat (3) @(negedge clk);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule